// File: doc/BRIEF.md
# Byte-Lane DRAM Strobe Sequencer

This block sits between a simple request/response host and a 16-bit asynchronous DRAM that has one row strobe, one write enable and a separate column strobe for each 8-bit byte lane. The host presents an address, write data, a two-bit lane mask and a read/write flag with a valid/ready handshake. The block puts the row half of the address on the multiplexed DRAM address bus, lowers the row strobe, waits a programmable number of clocks, puts out the column half and lowers the column strobe of each selected lane. It then holds for the column time, captures read data, raises every strobe and waits out the row precharge before it takes the next request. Each request ends in a single-cycle response pulse.

The two lanes share every control line except their column strobes. When both lanes are active they must use the same write mode. The block meets this by always using early writes: write enable goes low together with the row strobe, well before any column strobe falls, and it does not move while a column strobe is low. An external arbiter can grant a refresh. The block then runs a column-before-row refresh, which takes priority over a pending host request.

Top module: `bldc_top`

## Requirements
- R1: After reset, the row strobe, both column strobes and write enable are high (inactive), the data-bus drive enable is low and no response is signalled.
- R2: For an access, the row strobe is low for exactly T_RCD clocks before the first column strobe falls. The column strobes then stay low for exactly T_CAS clocks. The row address (upper ROW_W bits of the request address) is on the bus when the row strobe falls, and the column address (lower COL_W bits) is on the bus when the column strobes fall.
- R3: Lane mask bit 0 selects column strobe bit 0 and data bits 7:0. Mask bit 1 selects column strobe bit 1 and data bits 15:8. Mask 11 lowers both strobes together for a full-word access.
- R4: A write changes only the selected lanes of the addressed word; the other lane keeps its stored value.
- R5: Writes are early writes. Write enable is already low in the clock before a column strobe falls. Neither write enable nor the column-strobe pattern changes while any column strobe is low, so both lanes always share one mode.
- R6: A read returns the selected lanes on the response data, with unselected lanes reading as zero. The response pulse lasts one clock and comes in the clock in which the strobes return high.
- R7: Once the row strobe rises, it stays high for at least T_RP+1 clocks before it falls again.
- R8: A request with lane mask 00 is accepted and answered with a response pulse on the next clock. No row or column strobe moves.
- R9: While the refresh grant is high in the idle state, requests are not accepted. Both column strobes fall with write enable high, one clock before the row strobe falls. The row strobe stays low for T_RCD+T_CAS clocks, and a one-clock refresh-done pulse comes as all strobes rise.
- R10: The ready output is high only when the block is idle, all strobes are high and no refresh grant is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Lane mask, bit 0 low byte, bit 1 high byte |
| req_addr | input | ROW_W+COL_W | Word address, row in the upper bits |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| ref_grant | input | 1 | Refresh granted by the arbiter |
| ref_done | output | 1 | One-clock pulse at the end of a refresh |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 2 | Column strobe per lane, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | 16 | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 16 | Data returned by the DRAM |

## Verification
The assertions watch the strobe protocol on every clock. They check that write enable is settled before a column strobe falls and that write enable and the lane pattern are frozen while a column strobe is low. They also check that the row strobe never drops one clock after rising, that ready implies idle strobes, that any column strobe low with the row strobe high must be a both-lane refresh, and that a mask of 00 produces a response with no strobe activity. The exact T_RCD and T_CAS counts, the lane-to-data mapping, the preservation of the unselected lane in storage, the masking of read data and the full precharge length can only be shown by the bench's scenarios. There, a DRAM model stores bytes, counts strobe intervals and records mode and precharge violations while a scoreboard compares every response.

// File: rtl/bldc_pkg.sv
package bldc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_PRE,
        ST_RCAS,
        ST_RRAS
    } bldc_st_e;
endpackage

// File: rtl/bldc_wait_cnt.sv
module bldc_wait_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/bldc_addr_mux.sv
module bldc_addr_mux #(
    parameter int ROW_W = 10,
    parameter int COL_W = 10,
    parameter int BUS_W = 10
) (
    input  logic [ROW_W+COL_W-1:0] addr,
    input  logic                   sel_col,
    output logic [BUS_W-1:0]       bus
);
    localparam int AW = ROW_W + COL_W;

    always_comb begin
        if (sel_col) bus = BUS_W'(addr[COL_W-1:0]);
        else         bus = BUS_W'(addr[AW-1:COL_W]);
    end
endmodule

// File: rtl/bldc_top.sv
module bldc_top #(
    parameter int ROW_W  = 10,
    parameter int COL_W  = 10,
    parameter int LANE_W = 8,
    parameter int LANES  = 2,
    parameter int T_RCD  = 2,
    parameter int T_CAS  = 2,
    parameter int T_RP   = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  req_valid,
    output logic                                  req_ready,
    input  logic                                  req_we,
    input  logic [LANES-1:0]                      req_be,
    input  logic [ROW_W+COL_W-1:0]                req_addr,
    input  logic [LANE_W*LANES-1:0]               req_wdata,
    output logic                                  rsp_valid,
    output logic [LANE_W*LANES-1:0]               rsp_rdata,
    input  logic                                  ref_grant,
    output logic                                  ref_done,
    output logic [(ROW_W>COL_W?ROW_W:COL_W)-1:0]  dram_addr,
    output logic                                  dram_ras_n,
    output logic [LANES-1:0]                      dram_cas_n,
    output logic                                  dram_we_n,
    output logic [LANE_W*LANES-1:0]               dram_dq_out,
    output logic                                  dram_dq_oe,
    input  logic [LANE_W*LANES-1:0]               dram_dq_in
);
    import bldc_pkg::*;

    localparam int DATA_W = LANE_W * LANES;
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int BUS_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int T_REF  = T_RCD + T_CAS;
    localparam int T_MAX  = (T_REF > T_RP) ? T_REF : T_RP;
    localparam int CNT_W  = $clog2(T_MAX + 1);

    typedef struct packed {
        bldc_st_e          st;
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] wdata;
        logic [BUS_W-1:0]  bus;
        logic              ras_n;
        logic [LANES-1:0]  cas_n;
        logic              we_n;
        logic              oe;
        logic              rsp_v;
        logic [DATA_W-1:0] rdata;
        logic              ref_done;
    } regs_t;

    regs_t             d, q;
    logic              cnt_load;
    logic [CNT_W-1:0]  cnt_val;
    logic              cnt_zero;
    logic [BUS_W-1:0]  row_bus, col_bus;
    logic [DATA_W-1:0] cap_data;

    bldc_wait_cnt #(.CNT_W(CNT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .zero     (cnt_zero)
    );

    bldc_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .BUS_W(BUS_W)) u_row_mux (
        .addr    (req_addr),
        .sel_col (1'b0),
        .bus     (row_bus)
    );

    bldc_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .BUS_W(BUS_W)) u_col_mux (
        .addr    (q.addr),
        .sel_col (1'b1),
        .bus     (col_bus)
    );

    // read capture: unselected lanes forced to zero
    for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
        assign cap_data[gl*LANE_W +: LANE_W] =
            q.be[gl] ? dram_dq_in[gl*LANE_W +: LANE_W] : '0;
    end

    always_comb begin
        d          = q;
        d.rsp_v    = 1'b0;
        d.ref_done = 1'b0;
        cnt_load   = 1'b0;
        cnt_val    = '0;
        req_ready  = (q.st == ST_IDLE) && !ref_grant;
        unique case (q.st)
            ST_IDLE: begin
                if (ref_grant) begin
                    d.st     = ST_RCAS;
                    d.cas_n  = '0;
                    cnt_load = 1'b1;
                    cnt_val  = '0;
                end else if (req_valid) begin
                    d.addr  = req_addr;
                    d.we    = req_we;
                    d.be    = req_be;
                    d.wdata = req_wdata;
                    if (req_be == '0) begin
                        d.rsp_v = 1'b1;
                        d.rdata = '0;
                    end else begin
                        d.st     = ST_ROW;
                        d.ras_n  = 1'b0;
                        d.bus    = row_bus;
                        d.we_n   = !req_we;
                        d.oe     = req_we;
                        cnt_load = 1'b1;
                        cnt_val  = CNT_W'(T_RCD - 1);
                    end
                end
            end
            ST_ROW: begin
                if (cnt_zero) begin
                    d.st     = ST_COL;
                    d.bus    = col_bus;
                    d.cas_n  = ~q.be;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(T_CAS - 1);
                end
            end
            ST_COL: begin
                if (cnt_zero) begin
                    d.st     = ST_PRE;
                    d.ras_n  = 1'b1;
                    d.cas_n  = '1;
                    d.we_n   = 1'b1;
                    d.oe     = 1'b0;
                    d.rsp_v  = 1'b1;
                    d.rdata  = q.we ? '0 : cap_data;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(T_RP - 1);
                end
            end
            ST_PRE: begin
                if (cnt_zero) d.st = ST_IDLE;
            end
            ST_RCAS: begin
                if (cnt_zero) begin
                    d.st     = ST_RRAS;
                    d.ras_n  = 1'b0;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(T_REF - 1);
                end
            end
            ST_RRAS: begin
                if (cnt_zero) begin
                    d.st       = ST_PRE;
                    d.ras_n    = 1'b1;
                    d.cas_n    = '1;
                    d.ref_done = 1'b1;
                    cnt_load   = 1'b1;
                    cnt_val    = CNT_W'(T_RP - 1);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= ST_IDLE;
            q.ras_n    <= 1'b1;
            q.cas_n    <= '1;
            q.we_n     <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rsp_valid   = q.rsp_v;
    assign rsp_rdata   = q.rdata;
    assign ref_done    = q.ref_done;
    assign dram_addr   = q.bus;
    assign dram_ras_n  = q.ras_n;
    assign dram_cas_n  = q.cas_n;
    assign dram_we_n   = q.we_n;
    assign dram_dq_out = q.wdata;
    assign dram_dq_oe  = q.oe;
endmodule

// File: rtl/bldc_chk.sv
module bldc_chk #(
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [LANES-1:0] req_be,
    input logic             rsp_valid,
    input logic             ref_grant,
    input logic             ref_done,
    input logic             dram_ras_n,
    input logic [LANES-1:0] dram_cas_n,
    input logic             dram_we_n
);
    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R5
    early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && dram_cas_n != '1 && $past(dram_cas_n) == '1 && !dram_we_n)
            |-> $past(!dram_we_n));

    // R5
    lane_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && dram_cas_n != '1 && $past(dram_cas_n) != '1)
            |-> ($stable(dram_we_n) && dram_cas_n == $past(dram_cas_n)));

    // R8
    empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_be == '0)
            |=> (rsp_valid && dram_ras_n && dram_cas_n == '1));

    // R10
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (dram_ras_n && dram_cas_n == '1 && !ref_grant));

    // R7
    ras_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(dram_ras_n)) |=> dram_ras_n);

    // R9
    cbr_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_cas_n != '1 && dram_ras_n) |-> (dram_cas_n == '0 && dram_we_n));

    // R9
    ref_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_done |-> (dram_ras_n && dram_cas_n == '1));
endmodule

bind bldc_top bldc_chk #(.LANES(LANES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_be     (req_be),
    .rsp_valid  (rsp_valid),
    .ref_grant  (ref_grant),
    .ref_done   (ref_done),
    .dram_ras_n (dram_ras_n),
    .dram_cas_n (dram_cas_n),
    .dram_we_n  (dram_we_n)
);

// File: tb/bldc_top_tb.sv
module bldc_top_tb;
    localparam int ROW_W = 10;
    localparam int COL_W = 10;
    localparam int T_RCD = 2;
    localparam int T_CAS = 2;
    localparam int T_RP  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_we = 1'b0;
    logic [1:0]  req_be = 2'b00;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        ref_grant = 1'b0;
    logic        ref_done;
    logic [9:0]  dram_addr;
    logic        dram_ras_n;
    logic [1:0]  dram_cas_n;
    logic        dram_we_n;
    logic [15:0] dram_dq_out;
    logic        dram_dq_oe;
    logic [15:0] dram_dq_in;

    always #4 clk = ~clk;

    bldc_top #(.ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_be(req_be), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ref_grant(ref_grant), .ref_done(ref_done),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
        .dram_dq_in(dram_dq_in)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- DRAM model ----------------
    logic [15:0] mem [int];
    logic [9:0]  row_lat, col_lat;
    logic        prev_ras = 1'b1;
    logic [1:0]  prev_cas = 2'b11;
    logic        prev_we = 1'b1;
    int          ras_hi_cnt = 100;
    int          rcd_cnt = 0;
    int          cas_cnt = 0;
    bit          acc_cas = 1'b0;
    int          viol_mode = 0;
    int          viol_pre = 0;
    int          cbr_cnt = 0;
    int          strobe_falls = 0;
    logic [15:0] dq_m = '0;
    logic [1:0]  pat_q[$];

    assign dram_dq_in = dq_m;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ras && !dram_ras_n) begin
                strobe_falls++;
                if (ras_hi_cnt < T_RP + 1) viol_pre++;
                row_lat = dram_addr;
                rcd_cnt = 0;
                if (dram_cas_n == 2'b00 && prev_cas == 2'b00 && dram_we_n) cbr_cnt++;
            end
            if (dram_ras_n) ras_hi_cnt++;
            else            ras_hi_cnt = 0;
            if (!dram_ras_n && dram_cas_n == 2'b11) rcd_cnt++;
            if (prev_cas == 2'b11 && dram_cas_n != 2'b11) begin
                strobe_falls++;
                cas_cnt = 0;
                acc_cas = !dram_ras_n;
                if (!dram_ras_n) begin
                    int key;
                    // R2: row strobe low T_RCD clocks before column strobe
                    check(rcd_cnt == T_RCD, "R2 row-to-column clocks", rcd_cnt, T_RCD);
                    col_lat = dram_addr;
                    if (pat_q.size() > 0) begin
                        logic [1:0] ep;
                        ep = pat_q.pop_front();
                        // R3: column strobe pattern follows lane mask
                        check(dram_cas_n == ep, "R3 lane strobe pattern", dram_cas_n, ep);
                    end
                    if (!dram_we_n && prev_we) viol_mode++;
                    key = int'({row_lat, col_lat});
                    if (!dram_we_n) begin
                        if (!mem.exists(key)) mem[key] = 16'h0000;
                        if (!dram_cas_n[0]) mem[key][7:0]  = dram_dq_out[7:0];
                        if (!dram_cas_n[1]) mem[key][15:8] = dram_dq_out[15:8];
                    end else begin
                        logic [15:0] v;
                        v = mem.exists(key) ? mem[key] : 16'h0000;
                        dq_m = 16'h0000;
                        if (!dram_cas_n[0]) dq_m[7:0]  = v[7:0];
                        if (!dram_cas_n[1]) dq_m[15:8] = v[15:8];
                    end
                end
            end else if (prev_cas != 2'b11 && dram_cas_n != 2'b11) begin
                if (dram_cas_n != prev_cas || dram_we_n != prev_we) viol_mode++;
            end
            if (dram_cas_n != 2'b11) cas_cnt++;
            if (prev_cas != 2'b11 && dram_cas_n == 2'b11) begin
                if (acc_cas)
                    // R2: column strobe width
                    check(cas_cnt == T_CAS, "R2 column strobe clocks", cas_cnt, T_CAS);
                dq_m = 16'h0000;
            end
            prev_ras = dram_ras_n;
            prev_cas = dram_cas_n;
            prev_we  = dram_we_n;
        end
    end

    // ---------------- scoreboard ----------------
    logic [15:0] exp_q[$];
    bit          chk_q[$];
    string       tag_q[$];
    logic [15:0] shadow [int];

    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected response", 32'(rsp_rdata), 0);
            end else begin
                logic [15:0] e;
                bit c;
                string t;
                e = exp_q.pop_front();
                c = chk_q.pop_front();
                t = tag_q.pop_front();
                if (c) check(rsp_rdata == e, t, 32'(rsp_rdata), 32'(e));
            end
        end
    end

    task automatic do_req(input bit we, input logic [1:0] be, input logic [19:0] addr,
                          input logic [15:0] wd, input string tag);
        int key;
        logic [15:0] s;
        key = int'(addr);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_be = be; req_addr = addr; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        s = shadow.exists(key) ? shadow[key] : 16'h0000;
        if (be != 2'b00) pat_q.push_back(~be);
        if (we) begin
            if (be[0]) s[7:0]  = wd[7:0];
            if (be[1]) s[15:8] = wd[15:8];
            shadow[key] = s;
            exp_q.push_back(16'h0000); chk_q.push_back(1'b0);
        end else begin
            logic [15:0] e;
            e = 16'h0000;
            if (be[0]) e[7:0]  = s[7:0];
            if (be[1]) e[15:8] = s[15:8];
            exp_q.push_back(e); chk_q.push_back(1'b1);
        end
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        int guard = 0;
        while (exp_q.size() > 0 && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        repeat (T_RP + 2) @(negedge clk);
    endtask

    localparam logic [19:0] A1 = {10'h155, 10'h0AA};
    localparam logic [19:0] A2 = {10'h2AA, 10'h155};

    initial begin
        int falls0, cbr0, wait_n;
        bit seen;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(dram_ras_n == 1'b1, "R1 row strobe idle", dram_ras_n, 1);
        check(dram_cas_n == 2'b11, "R1 column strobes idle", dram_cas_n, 2'b11);
        check(dram_we_n == 1'b1 && dram_dq_oe == 1'b0, "R1 write enable and drive idle",
              {dram_we_n, dram_dq_oe}, 2'b10);
        check(rsp_valid == 1'b0, "R1 no response", rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: ready when idle
        check(req_ready == 1'b1, "R10 ready in idle", req_ready, 1);

        // R3 R4 R6: word write and read
        do_req(1'b1, 2'b11, A1, 16'hA5C3, "R3 word write");
        do_req(1'b0, 2'b11, A1, 16'h0000, "R6 word read");
        // R4: low-lane write keeps high lane
        do_req(1'b1, 2'b01, A1, 16'hFF12, "R4 low lane write");
        do_req(1'b0, 2'b11, A1, 16'h0000, "R4 high lane kept");
        // R4: high-lane write keeps low lane
        do_req(1'b1, 2'b10, A1, 16'h7E00, "R4 high lane write");
        do_req(1'b0, 2'b01, A1, 16'h0000, "R6 low lane read, high zero");
        do_req(1'b0, 2'b10, A1, 16'h0000, "R6 high lane read, low zero");
        // R2: other address does not alias
        do_req(1'b1, 2'b11, A2, 16'h3C96, "R2 second word write");
        do_req(1'b0, 2'b11, A1, 16'h0000, "R2 first word intact");
        do_req(1'b0, 2'b11, A2, 16'h0000, "R2 second word read");
        drain();

        // R8: empty mask
        falls0 = strobe_falls;
        do_req(1'b1, 2'b00, A1, 16'hFFFF, "R8 empty mask response");
        drain();
        check(strobe_falls == falls0, "R8 no strobe activity", strobe_falls, falls0);
        do_req(1'b0, 2'b11, A1, 16'h0000, "R8 data unchanged");
        drain();

        // R9: refresh
        cbr0 = cbr_cnt;
        @(negedge clk);
        ref_grant = 1'b1;
        #1;
        check(req_ready == 1'b0, "R9 ready held off by grant", req_ready, 0);
        seen = 1'b0;
        wait_n = 0;
        while (!seen && wait_n < 100) begin
            @(negedge clk);
            wait_n++;
            if (ref_done) seen = 1'b1;
        end
        ref_grant = 1'b0;
        check(seen, "R9 refresh done pulse", seen, 1);
        check(cbr_cnt == cbr0 + 1, "R9 column-before-row order", cbr_cnt, cbr0 + 1);
        do_req(1'b0, 2'b11, A2, 16'h0000, "R9 data after refresh");
        drain();

        // R5 R7: protocol counters from the model
        check(viol_mode == 0, "R5 mode violations", viol_mode, 0);
        check(viol_pre == 0, "R7 precharge violations", viol_pre, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule